// File: doc/BRIEF.md
# Two-Master Priority Bus Fabric

This block joins two bus masters to a set of memory-mapped slaves over one shared path, using classic single-beat bus cycles with 32-bit data. While one master holds the path, the other waits. When both ask for it from an idle state, master 0 is given the path. The path stays with the master that won it until that master drops its cycle signal.

The address from the owning master is matched against a base and mask pair for each slave. These pairs are parameters. Any address that no slave claims goes to a catch-all port at the highest slave index, where a second fabric can be chained. Write data, address, byte enables and the write flag go to every slave in common. Cycle and strobe go only to the addressed slave, and only that slave's response is returned to the owner.

An optional watchdog stops a master from waiting forever. If the addressed slave gives no response within a set number of clock cycles, the watchdog returns a one-cycle error to the owning master.

Top module: `bus_fabric2m`

## Requirements
- R1: At most one slave port sees its cycle line high in any cycle, and only the owning master's request reaches the slaves.
- R2: When the path is idle and both masters raise cycle in the same clock, master 0 is granted.
- R3: A granted master keeps the path for as long as its cycle line stays high. When it drops cycle, the other master can be granted in that same clock.
- R4: Slave i (0 to NSLV-1) is selected when (address AND MASK_i) equals BASE_i. If two regions overlap, the lower index wins. Defaults: slave 0 base 0x0000_0000 mask 0xF000_0000; slave 1 base 0x1000_0000 mask 0xF000_0000; slave 2 base 0x2000_0000 mask 0xFF00_0000.
- R5: An address that matches no slave selects the catch-all port, index NSLV (3 by default).
- R6: Cycle and strobe are driven only to the selected slave. Ack, err and rty from any slave that is not selected have no effect on the masters.
- R7: Read data and the ack, err and rty flags of the selected slave are returned to the owning master. The master that is not granted sees ack, err and rty low.
- R8: With the watchdog enabled, a cycle that gets no ack, err or rty has err raised to the owner in its TO_CYCLES-th clock (default 16). Err stays high for exactly one clock, then the count starts again.
- R9: The watchdog count returns to zero whenever no strobed cycle is active or a response arrives. A cycle that is interrupted therefore gets a full new window.
- R10: Address, 32-bit write data, byte enables and the write flag of the owning master appear unchanged on the shared slave outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m0_cyc | input | 1 | Master 0 cycle request |
| m0_stb | input | 1 | Master 0 strobe |
| m0_we | input | 1 | Master 0 write flag |
| m0_sel | input | 4 | Master 0 byte enables |
| m0_adr | input | 32 | Master 0 address |
| m0_wdat | input | 32 | Master 0 write data |
| m0_rdat | output | 32 | Read data to master 0 |
| m0_ack | output | 1 | Ack to master 0 |
| m0_err | output | 1 | Error to master 0 |
| m0_rty | output | 1 | Retry to master 0 |
| m1_cyc | input | 1 | Master 1 cycle request |
| m1_stb | input | 1 | Master 1 strobe |
| m1_we | input | 1 | Master 1 write flag |
| m1_sel | input | 4 | Master 1 byte enables |
| m1_adr | input | 32 | Master 1 address |
| m1_wdat | input | 32 | Master 1 write data |
| m1_rdat | output | 32 | Read data to master 1 |
| m1_ack | output | 1 | Ack to master 1 |
| m1_err | output | 1 | Error to master 1 |
| m1_rty | output | 1 | Retry to master 1 |
| s_cyc | output | NSLV+1 | Per-slave cycle, catch-all port at the top index |
| s_stb | output | NSLV+1 | Per-slave strobe |
| s_we | output | 1 | Shared write flag |
| s_sel | output | 4 | Shared byte enables |
| s_adr | output | 32 | Shared address |
| s_wdat | output | 32 | Shared write data |
| s_rdat | input | 32*(NSLV+1) | Read data, slave i in bits [32i+31:32i] |
| s_ack | input | NSLV+1 | Per-slave ack |
| s_err | input | NSLV+1 | Per-slave error |
| s_rty | input | NSLV+1 | Per-slave retry |

## Verification
The hardest case to reach is the grant-hold rule. Master 0 must be held off while master 1 owns the path, and must take over in the very clock that master 1 lets go. The stimulus first lets master 1 win alone on an idle path, then raises master 0 on top of it, then drops master 1 with master 0 still asking. The watchdog window is tested against the catch-all port with its ack turned off. The window is also cut short by briefly dropping cycle, which shows that the count restarts. To show that an unselected slave is ignored, the bench makes one slave ack all the time while a different, silent slave is addressed.

// File: rtl/bus_fabric_pkg.sv
// Package: shared widths and the request bundle used inside the fabric.
// Assumes classic single-beat cycles only.
package bus_fabric_pkg;
    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;
    localparam int unsigned SW = DW / 8;

    typedef struct packed {
        logic          cyc;
        logic          stb;
        logic          we;
        logic [SW-1:0] sel;
        logic [AW-1:0] adr;
        logic [DW-1:0] wdat;
    } mreq_t;
endpackage

// File: rtl/bus_fabric_arb.sv
// Two-way fixed-priority arbiter with ownership hold.
// Master 0 wins from idle; the owner keeps the grant while its cycle stays high.
module bus_fabric_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    output logic       gnt_vld,
    output logic       gnt_id
);
    logic busy_q;
    logic owner_q;

    // Pick the grant: keep a live owner, otherwise fixed priority.
    always_comb begin
        if (busy_q && req[owner_q]) begin
            gnt_vld = 1'b1;
            gnt_id  = owner_q;
        end else begin
            gnt_vld = |req;
            gnt_id  = ~req[0] & req[1];
        end
    end

    // Remember who holds the path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            owner_q <= 1'b0;
        end else begin
            busy_q  <= gnt_vld;
            owner_q <= gnt_id;
        end
    end

    AST_PRIO_M0: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && req == 2'b11) |-> (gnt_vld && gnt_id == 1'b0)); // R2
    AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && req[gnt_id]) |=> (!req[$past(gnt_id)] || gnt_id == $past(gnt_id))); // R3
endmodule

// File: rtl/bus_fabric_dec.sv
// Address decoder: base/mask match per slave, lowest index wins on overlap,
// the top index is the catch-all and is taken when no region matches.
module bus_fabric_dec #(
    parameter int unsigned NSLV = 3,
    parameter int unsigned AW   = 32,
    parameter logic [NSLV*AW-1:0] BASE = '0,
    parameter logic [NSLV*AW-1:0] MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   adr,
    output logic [NSLV:0]   sel
);
    logic [NSLV-1:0] hit;

    // Raw region match for each explicit slave.
    for (genvar i = 0; i < NSLV; i++) begin : g_hit
        assign hit[i] = ((adr & MASK[i*AW +: AW]) == BASE[i*AW +: AW]);
    end

    // Priority among overlapping hits, catch-all when none hit.
    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < NSLV; i++) begin
            sel[i] = hit[i] & ~taken;
            taken  = taken | hit[i];
        end
        sel[NSLV] = ~taken;
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(sel)); // R5
    AST_CATCHALL: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> sel[NSLV]); // R5
endmodule

// File: rtl/bus_fabric_wdog.sv
// Response watchdog: counts clocks of an active strobed cycle without a reply
// and raises a one-clock timeout in the TO_CYCLES-th such clock.
// With EN = 0 the timeout is tied low.
module bus_fabric_wdog #(
    parameter bit          EN        = 1'b1,
    parameter int unsigned TO_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic resp,
    output logic timeout
);
    localparam int unsigned CW = (TO_CYCLES > 2) ? $clog2(TO_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TO_CYCLES - 1);

    if (EN) begin : g_on
        logic [CW-1:0] cnt_q;

        assign timeout = active && !resp && (cnt_q == LAST);

        // Count waiting clocks; restart on idle, reply or timeout.
        always_ff @(posedge clk) begin
            if (!rst_n || !active || resp || timeout) cnt_q <= '0;
            else                                      cnt_q <= cnt_q + 1'b1;
        end

        AST_WD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            timeout |=> !timeout); // R8
        AST_WD_IDLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            !active |=> !timeout); // R9
    end else begin : g_off
        assign timeout = 1'b0;
    end
endmodule

// File: rtl/bus_fabric2m.sv
// Two-master bus fabric top: arbitrates, muxes the owner's request onto a
// shared slave path, decodes the target, gates cycle/strobe to that target and
// returns its response (plus watchdog error) to the owner only.
// Assumes classic single-beat cycles; slaves sit in the same clock domain.
module bus_fabric2m
    import bus_fabric_pkg::*;
#(
    parameter int unsigned NSLV      = 3,
    parameter logic [NSLV*32-1:0] SLV_BASE = {32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
    parameter logic [NSLV*32-1:0] SLV_MASK = {32'hFF00_0000, 32'hF000_0000, 32'hF000_0000},
    parameter bit          WDOG_EN   = 1'b1,
    parameter int unsigned TO_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 m0_cyc,
    input  logic                 m0_stb,
    input  logic                 m0_we,
    input  logic [3:0]           m0_sel,
    input  logic [31:0]          m0_adr,
    input  logic [31:0]          m0_wdat,
    output logic [31:0]          m0_rdat,
    output logic                 m0_ack,
    output logic                 m0_err,
    output logic                 m0_rty,
    input  logic                 m1_cyc,
    input  logic                 m1_stb,
    input  logic                 m1_we,
    input  logic [3:0]           m1_sel,
    input  logic [31:0]          m1_adr,
    input  logic [31:0]          m1_wdat,
    output logic [31:0]          m1_rdat,
    output logic                 m1_ack,
    output logic                 m1_err,
    output logic                 m1_rty,
    output logic [NSLV:0]        s_cyc,
    output logic [NSLV:0]        s_stb,
    output logic                 s_we,
    output logic [3:0]           s_sel,
    output logic [31:0]          s_adr,
    output logic [31:0]          s_wdat,
    input  logic [(NSLV+1)*32-1:0] s_rdat,
    input  logic [NSLV:0]        s_ack,
    input  logic [NSLV:0]        s_err,
    input  logic [NSLV:0]        s_rty
);
    localparam int unsigned NP = NSLV + 1;

    mreq_t          req0, req1, own;
    logic           gnt_vld, gnt_id;
    logic [NSLV:0]  dsel;
    logic           r_ack, r_err, r_rty, tmo;
    logic [DW-1:0]  r_dat;

    assign req0 = '{cyc: m0_cyc, stb: m0_stb, we: m0_we, sel: m0_sel, adr: m0_adr, wdat: m0_wdat};
    assign req1 = '{cyc: m1_cyc, stb: m1_stb, we: m1_we, sel: m1_sel, adr: m1_adr, wdat: m1_wdat};

    bus_fabric_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     ({m1_cyc, m0_cyc}),
        .gnt_vld (gnt_vld),
        .gnt_id  (gnt_id)
    );

    // Owner request bundle; nothing passes without a grant.
    always_comb begin
        own = gnt_id ? req1 : req0;
        if (!gnt_vld) begin
            own.cyc = 1'b0;
            own.stb = 1'b0;
        end
    end

    bus_fabric_dec #(
        .NSLV (NSLV),
        .AW   (AW),
        .BASE (SLV_BASE),
        .MASK (SLV_MASK)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .adr   (own.adr),
        .sel   (dsel)
    );

    // Shared request fields go to every slave.
    assign s_we   = own.we;
    assign s_sel  = own.sel;
    assign s_adr  = own.adr;
    assign s_wdat = own.wdat;

    // Per-slave gating of cycle and strobe.
    for (genvar i = 0; i < NP; i++) begin : g_slv
        assign s_cyc[i] = own.cyc & dsel[i];
        assign s_stb[i] = own.cyc & own.stb & dsel[i];
    end

    // Return path: only the selected slave is heard.
    always_comb begin
        r_dat = '0;
        for (int i = 0; i < NP; i++) begin
            if (dsel[i]) r_dat = s_rdat[i*DW +: DW];
        end
        r_ack = |(s_ack & dsel) & own.cyc;
        r_err = |(s_err & dsel) & own.cyc;
        r_rty = |(s_rty & dsel) & own.cyc;
    end

    bus_fabric_wdog #(
        .EN        (WDOG_EN),
        .TO_CYCLES (TO_CYCLES)
    ) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (own.cyc & own.stb),
        .resp    (r_ack | r_err | r_rty),
        .timeout (tmo)
    );

    // Steer the response to the owner only.
    always_comb begin
        m0_rdat = r_dat;
        m1_rdat = r_dat;
        m0_ack  = r_ack & ~gnt_id;
        m0_err  = (r_err | tmo) & gnt_vld & ~gnt_id;
        m0_rty  = r_rty & ~gnt_id;
        m1_ack  = r_ack & gnt_id;
        m1_err  = (r_err | tmo) & gnt_vld & gnt_id;
        m1_rty  = r_rty & gnt_id;
    end

    AST_ONE_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_cyc)); // R1
    AST_STB_IN_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_stb & ~s_cyc) == '0)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!m0_cyc && !m1_cyc) |-> (s_cyc == '0)); // R1
    AST_M1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !m1_cyc |-> !(m1_ack || m1_err || m1_rty)); // R7
    AST_M0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !m0_cyc |-> !(m0_ack || m0_err || m0_rty)); // R7
endmodule

// File: tb/bus_fabric2m_test.sv
module bus_fabric2m_test;
    localparam int NS = 4;
    localparam int TO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic m0_cyc = 0, m0_stb = 0, m0_we = 0, m1_cyc = 0, m1_stb = 0, m1_we = 0;
    logic [3:0]  m0_sel = 0, m1_sel = 0;
    logic [31:0] m0_adr = 0, m0_wdat = 0, m1_adr = 0, m1_wdat = 0;
    logic [31:0] m0_rdat, m1_rdat;
    logic m0_ack, m0_err, m0_rty, m1_ack, m1_err, m1_rty;
    logic [NS-1:0] s_cyc, s_stb, s_ack, s_err, s_rty;
    logic s_we;
    logic [3:0] s_sel;
    logic [31:0] s_adr, s_wdat;
    logic [NS*32-1:0] s_rdat;

    logic [NS-1:0] ack_en = '1, err_en = '0, force_ack = '0;

    // Slave models: reply with a data word tagged by index and address.
    always_comb begin
        for (int i = 0; i < NS; i++) begin
            s_ack[i] = (s_cyc[i] & s_stb[i] & ack_en[i]) | force_ack[i];
            s_err[i] = s_cyc[i] & s_stb[i] & err_en[i];
            s_rty[i] = 1'b0;
            s_rdat[i*32 +: 32] = 32'hC000_0000 | (32'(i) << 24) | {16'h0, s_adr[15:0]};
        end
    end

    bus_fabric2m uut (
        .clk(clk), .rst_n(rst_n),
        .m0_cyc(m0_cyc), .m0_stb(m0_stb), .m0_we(m0_we), .m0_sel(m0_sel),
        .m0_adr(m0_adr), .m0_wdat(m0_wdat), .m0_rdat(m0_rdat),
        .m0_ack(m0_ack), .m0_err(m0_err), .m0_rty(m0_rty),
        .m1_cyc(m1_cyc), .m1_stb(m1_stb), .m1_we(m1_we), .m1_sel(m1_sel),
        .m1_adr(m1_adr), .m1_wdat(m1_wdat), .m1_rdat(m1_rdat),
        .m1_ack(m1_ack), .m1_err(m1_err), .m1_rty(m1_rty),
        .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_sel(s_sel),
        .s_adr(s_adr), .s_wdat(s_wdat), .s_rdat(s_rdat),
        .s_ack(s_ack), .s_err(s_err), .s_rty(s_rty)
    );

    // Scoreboard items: which port to probe and the expected value.
    typedef struct {
        string       req;
        int          kind;
        logic [63:0] exp;
    } item_t;
    item_t sbq[$];
    int checks = 0;
    int fails  = 0;

    function automatic logic [63:0] probe(int kind);
        case (kind)
            0: return 64'({m0_ack, m0_err, m0_rty});
            1: return 64'({m1_ack, m1_err, m1_rty});
            2: return 64'(m0_rdat);
            3: return 64'(s_cyc);
            4: return 64'(s_adr);
            5: return 64'({s_we, s_sel, s_wdat});
            6: return 64'(m1_rdat);
            default: return 64'hDEAD;
        endcase
    endfunction

    task automatic expect_item(string req, int kind, logic [63:0] exp);
        sbq.push_back('{req: req, kind: kind, exp: exp});
    endtask

    // Monitor: pops expectations after the driver has settled inputs.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sbq.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it  = sbq.pop_front();
                act = probe(it.kind);
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic drive(int m, logic cyc, logic [31:0] adr);
        if (m == 0) begin m0_cyc = cyc; m0_stb = cyc; m0_adr = adr; end
        else        begin m1_cyc = cyc; m1_stb = cyc; m1_adr = adr; end
    endtask

    task automatic idle();
        @(negedge clk);
        drive(0, 0, 0);
        drive(1, 0, 0);
    endtask

    // Single read by master 0 to an address with expected target index.
    task automatic read_m0(string req, logic [31:0] adr, int tgt);
        @(negedge clk);
        drive(0, 1, adr);
        #1;
        expect_item(req, 3, 64'(1 << tgt));
        expect_item(req, 0, 64'b100);
        expect_item(req, 2, 64'(32'hC000_0000 | (32'(tgt) << 24) | {16'h0, adr[15:0]}));
        expect_item("R7", 1, 64'b000);
        idle();
    endtask

    bit wd_expired = 0;
    initial begin
        repeat (5000) @(posedge clk);
        wd_expired = 1;
    end

    initial begin
        fork
            begin
                // Reset state.
                repeat (3) @(negedge clk);
                #1;
                expect_item("R1", 3, 64'h0);
                expect_item("R7", 0, 64'b000);
                @(negedge clk);
                rst_n = 1'b1;

                // R4 decode of each explicit region, R5 catch-all.
                read_m0("R4", 32'h0000_0012, 0);
                read_m0("R4", 32'h1000_0034, 1);
                read_m0("R4", 32'h2000_0056, 2);
                read_m0("R5", 32'h2100_0078, 3);
                read_m0("R5", 32'h5000_0000, 3);

                // R10 shared request fields from the owner (master 1, a write).
                @(negedge clk);
                m1_we = 1; m1_sel = 4'hA; m1_wdat = 32'h1234_5678;
                drive(1, 1, 32'h1000_0100);
                #1;
                expect_item("R10", 4, 64'h1000_0100);
                expect_item("R10", 5, {27'h0, 1'b1, 4'hA, 32'h1234_5678});
                expect_item("R7", 1, 64'b100);
                expect_item("R7", 6, 64'hC100_0100);
                idle();
                m1_we = 0; m1_sel = 0; m1_wdat = 0;

                // R2 simultaneous request from idle.
                @(negedge clk);
                drive(0, 1, 32'h0000_0004);
                drive(1, 1, 32'h1000_0008);
                #1;
                expect_item("R2", 3, 64'b0001);
                expect_item("R2", 0, 64'b100);
                expect_item("R2", 1, 64'b000);
                idle();

                // R3 hold: master 1 wins alone, then master 0 joins.
                @(negedge clk);
                drive(1, 1, 32'h1000_0010);
                #1;
                expect_item("R3", 3, 64'b0010);
                @(negedge clk);
                drive(0, 1, 32'h0000_0020);
                #1;
                expect_item("R3", 3, 64'b0010);
                expect_item("R3", 1, 64'b100);
                expect_item("R3", 0, 64'b000);
                expect_item("R3", 4, 64'h1000_0010);
                @(negedge clk);
                #1;
                expect_item("R3", 3, 64'b0010);
                // Owner lets go; master 0 takes over in the same clock.
                @(negedge clk);
                drive(1, 0, 0);
                #1;
                expect_item("R3", 3, 64'b0001);
                expect_item("R3", 0, 64'b100);
                idle();

                // R6 a foreign ack is ignored while a silent slave is addressed.
                @(negedge clk);
                ack_en[0] = 0; force_ack[2] = 1;
                drive(0, 1, 32'h0000_0040);
                #1;
                expect_item("R6", 3, 64'b0001);
                expect_item("R6", 0, 64'b000);
                idle();
                ack_en[0] = 1; force_ack[2] = 0;

                // R7 error from the selected slave reaches the owner.
                @(negedge clk);
                err_en[1] = 1; ack_en[1] = 0;
                drive(0, 1, 32'h1000_0000);
                #1;
                expect_item("R7", 0, 64'b010);
                idle();
                err_en[1] = 0; ack_en[1] = 1;
                @(negedge clk);

                // R8 watchdog on a silent catch-all slave.
                ack_en[3] = 0;
                @(negedge clk);
                drive(0, 1, 32'h7000_0000);
                for (int j = 0; j <= TO; j++) begin
                    #1;
                    expect_item("R8", 0, (j == TO - 1) ? 64'b010 : 64'b000);
                    @(negedge clk);
                end
                drive(0, 0, 0);
                @(negedge clk);

                // R9 an interrupted wait restarts the window.
                drive(0, 1, 32'h7000_0000);
                for (int j = 0; j < 10; j++) begin
                    #1;
                    expect_item("R9", 0, 64'b000);
                    @(negedge clk);
                end
                drive(0, 0, 0);
                @(negedge clk);
                drive(0, 1, 32'h7000_0000);
                for (int j = 0; j <= TO; j++) begin
                    #1;
                    expect_item("R9", 0, (j == TO - 1) ? 64'b010 : 64'b000);
                    @(negedge clk);
                end
                drive(0, 0, 0);
                ack_en[3] = 1;
                repeat (3) @(negedge clk);
            end
            begin
                wait (wd_expired);
            end
        join_any
        if (wd_expired) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before the sequence finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule